// File: doc/BRIEF.md
# Translation Cache with Scoped Invalidation

This block is a small fully associative cache of finished DMA address translations. It sits between the request path of an I/O address remapper and its page-table walker. Each entry holds a domain identifier, a guest page number, a host page number and a page size of 4 KB, 2 MB or 1 GB. A lookup port answers hit or miss in the same cycle and returns the translated host page number. After a walk the walker offers the result on a fill port. A walk that faulted, or that hit a not-present table entry, is flagged on that port and never cached.

Software-driven flushes arrive on an invalidation port. A flush removes every entry, every entry of one domain, or every entry of one domain whose range covers a given guest page, large pages included. The entries are removed in the cycle the request is accepted. Completion is reported later on a one-cycle done pulse. That pulse waits until a counter of translated reads and writes still in flight has drained to zero. The counter is kept by the block from issue and retire strobes. While a flush is in progress, walker fills are discarded.

Top module: `iotlb_scoped`

## Requirements
- R1: A lookup with `lk_valid` high gives `lk_hit` in the same cycle when a valid entry has an equal domain ID and a guest page number equal to `lk_gpn` in every bit above the size-dependent low bits. If several entries match, the lowest-index entry supplies the result.
- R2: Size codes are 0 = 4 KB (no low bits ignored), 1 = 2 MB (low 9 page bits ignored) and 2 = 1 GB (low 18 page bits ignored). On a hit, `lk_hpn` is the stored host page number with its ignored low bits replaced by those of `lk_gpn`, and `lk_size` is the stored code.
- R3: A fill with `fill_fault` high changes no entry.
- R4: An accepted fill overwrites the lowest-index entry that its own domain and page would hit. If no entry would hit, it takes the lowest-index invalid entry. If every entry is valid, it replaces the entry under a victim pointer. The pointer is 0 after reset and advances by one, modulo the entry count, on each such replacement.
- R5: A fill is discarded in the cycle an invalidation is accepted and in every cycle until the cycle after `inv_done`.
- R6: `inv_req` is accepted only when no invalidation is in progress. `inv_done` pulses for one cycle, at the earliest two cycles after acceptance. It is raised only in the cycle after one in which the pending count was zero. The count rises by one on `pend_inc`, falls by one on `pend_dec`, and is unchanged when both strobes are high.
- R7: Scope 0 invalidates every entry.
- R8: Scope 1 invalidates every entry whose domain ID equals `inv_did`.
- R9: Scope 2 invalidates every entry with domain `inv_did` whose range covers `inv_gpn`, using the same size masking as a lookup. Scope 3 invalidates nothing but still completes with `inv_done`.
- R10: A lookup in the same cycle as an accepted invalidation already misses on the entries that the invalidation removes.
- R11: After reset no entry is valid, `lk_hit` and `inv_done` are low, and the pending count is zero.
- R12: An `inv_req` raised while an invalidation is in progress is ignored: it removes nothing and produces no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_did | input | DID_W | Lookup domain ID |
| lk_gpn | input | 36 | Lookup guest page number |
| lk_hit | output | 1 | Lookup hit, same cycle |
| lk_hpn | output | 34 | Translated host page number |
| lk_size | output | 2 | Page size code of the hit entry |
| fill_valid | input | 1 | Walker result offered |
| fill_fault | input | 1 | Walk faulted or found a not-present entry |
| fill_did | input | DID_W | Fill domain ID |
| fill_gpn | input | 36 | Fill guest page number |
| fill_hpn | input | 34 | Fill host page number |
| fill_size | input | 2 | Fill page size code |
| inv_req | input | 1 | Invalidation request |
| inv_scope | input | 2 | 0 all, 1 domain, 2 page, 3 none |
| inv_did | input | DID_W | Invalidation domain ID |
| inv_gpn | input | 36 | Invalidation guest page number |
| inv_done | output | 1 | Invalidation complete pulse |
| pend_inc | input | 1 | A translated access was issued |
| pend_dec | input | 1 | A translated access retired |

## Verification
The bench builds the block with ENTRIES=4, DID_W=8 and PEND_W=4. With four entries, a handful of fills fills the table. This brings full-table victim replacement and pointer wraparound within a few cycles. Overlapping large and small pages of two domains then also collide often. The random phase uses this to hit multi-match priority, scoped removal of large pages and invalidations that stall on a non-zero pending count.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;
  localparam int GA_W   = 48;
  localparam int PA_W   = 46;
  localparam int PG_SH  = 12;
  localparam int GPN_W  = GA_W - PG_SH;
  localparam int HPN_W  = PA_W - PG_SH;
  localparam int MID_SH = 9;
  localparam int BIG_SH = 18;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_2M  = 2'd1,
    PG_1G  = 2'd2,
    PG_RSV = 2'd3
  } pg_size_e;

  typedef enum logic [1:0] {
    INV_ALL  = 2'd0,
    INV_DOM  = 2'd1,
    INV_PAGE = 2'd2,
    INV_NONE = 2'd3
  } inv_scope_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_DONE  = 2'd2
  } inv_state_e;

  // Bits of a page number that take part in a compare, per size.
  function automatic logic [GPN_W-1:0] size_mask(pg_size_e sz);
    logic [GPN_W-1:0] m;
    m = '1;
    case (sz)
      PG_2M:   m = {{(GPN_W-MID_SH){1'b1}}, {MID_SH{1'b0}}};
      PG_1G:   m = {{(GPN_W-BIG_SH){1'b1}}, {BIG_SH{1'b0}}};
      default: m = '1;
    endcase
    return m;
  endfunction

  function automatic logic page_covers(logic [GPN_W-1:0] tag, pg_size_e sz,
                                       logic [GPN_W-1:0] probe);
    return ((tag ^ probe) & size_mask(sz)) == '0;
  endfunction

  // Upper bits from the stored frame, offset-within-page bits from the probe.
  function automatic logic [HPN_W-1:0] join_hpn(logic [HPN_W-1:0] base, pg_size_e sz,
                                                logic [GPN_W-1:0] probe);
    logic [GPN_W-1:0] m;
    m = size_mask(sz);
    return (base & m[HPN_W-1:0]) | (probe[HPN_W-1:0] & ~m[HPN_W-1:0]);
  endfunction
endpackage

// File: rtl/iotlb_entry.sv
module iotlb_entry
  import iotlb_pkg::*;
#(
  parameter int DID_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DID_W-1:0] wr_did,
  input  logic [GPN_W-1:0] wr_gpn,
  input  logic [HPN_W-1:0] wr_hpn,
  input  pg_size_e         wr_size,
  input  logic             inv_fire,
  input  inv_scope_e       inv_scope,
  input  logic [DID_W-1:0] inv_did,
  input  logic [GPN_W-1:0] inv_gpn,
  input  logic [DID_W-1:0] lk_did,
  input  logic [GPN_W-1:0] lk_gpn,
  output logic             valid,
  output logic             lk_match,
  output logic             fl_match,
  output logic             kill,
  output logic [HPN_W-1:0] hpn,
  output pg_size_e         size
);
  logic [DID_W-1:0] did_q;
  logic [GPN_W-1:0] gpn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      did_q <= '0;
      gpn_q <= '0;
      hpn   <= '0;
      size  <= PG_4K;
    end else if (kill) begin
      valid <= 1'b0;
    end else if (wr_en) begin
      valid <= 1'b1;
      did_q <= wr_did;
      gpn_q <= wr_gpn;
      hpn   <= wr_hpn;
      size  <= wr_size;
    end
  end

  assign lk_match = valid && (did_q == lk_did) && page_covers(gpn_q, size, lk_gpn);
  assign fl_match = valid && (did_q == wr_did) && page_covers(gpn_q, size, wr_gpn);

  always_comb begin
    kill = 1'b0;
    if (inv_fire && valid) begin
      case (inv_scope)
        INV_ALL:  kill = 1'b1;
        INV_DOM:  kill = (did_q == inv_did);
        INV_PAGE: kill = (did_q == inv_did) && page_covers(gpn_q, size, inv_gpn);
        default:  kill = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/iotlb_victim.sv
module iotlb_victim #(
  parameter int ENTRIES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] hit_vec,
  input  logic               alloc,
  output logic [ENTRIES-1:0] wr_vec,
  output logic               evict
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [IDX_W-1:0] rr_q;
  logic             any_hit;
  logic             full;

  assign any_hit = |hit_vec;
  assign full    = &valid_vec;
  assign evict   = alloc && !any_hit && full;

  always_comb begin
    logic found;
    found  = 1'b0;
    wr_vec = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && hit_vec[i]) begin
        wr_vec[i] = alloc;
        found     = 1'b1;
      end
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && !valid_vec[i]) begin
        wr_vec[i] = alloc;
        found     = 1'b1;
      end
    end
    if (evict) wr_vec[rr_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (evict) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/iotlb_inval_ctl.sv
module iotlb_inval_ctl
  import iotlb_pkg::*;
#(
  parameter int PEND_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_req,
  input  logic              pend_inc,
  input  logic              pend_dec,
  output logic              inv_fire,
  output logic              busy,
  output logic              inv_done,
  output logic              pend_zero,
  output logic [PEND_W-1:0] pend_cnt
);
  inv_state_e st_q, st_d;

  assign busy      = (st_q != ST_IDLE);
  assign inv_fire  = inv_req && (st_q == ST_IDLE);
  assign inv_done  = (st_q == ST_DONE);
  assign pend_zero = (pend_cnt == '0);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (inv_req) st_d = ST_DRAIN;
      ST_DRAIN: if (pend_zero) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      pend_cnt <= '0;
    end else begin
      st_q <= st_d;
      case ({pend_inc, pend_dec})
        2'b10:   pend_cnt <= pend_cnt + 1'b1;
        2'b01:   pend_cnt <= pend_cnt - 1'b1;
        default: pend_cnt <= pend_cnt;
      endcase
    end
  end
endmodule

// File: rtl/iotlb_scoped.sv
module iotlb_scoped
  import iotlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int DID_W   = 16,
  parameter int PEND_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [DID_W-1:0] lk_did,
  input  logic [GPN_W-1:0] lk_gpn,
  output logic             lk_hit,
  output logic [HPN_W-1:0] lk_hpn,
  output logic [1:0]       lk_size,
  input  logic             fill_valid,
  input  logic             fill_fault,
  input  logic [DID_W-1:0] fill_did,
  input  logic [GPN_W-1:0] fill_gpn,
  input  logic [HPN_W-1:0] fill_hpn,
  input  logic [1:0]       fill_size,
  input  logic             inv_req,
  input  logic [1:0]       inv_scope,
  input  logic [DID_W-1:0] inv_did,
  input  logic [GPN_W-1:0] inv_gpn,
  output logic             inv_done,
  input  logic             pend_inc,
  input  logic             pend_dec
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_vec, lk_vec, fl_vec, kill_vec, wr_vec, live_vec;
  logic [HPN_W-1:0]   e_hpn  [ENTRIES];
  pg_size_e           e_size [ENTRIES];
  logic               inv_fire, busy, pend_zero, fill_ok, evict;
  logic [PEND_W-1:0]  pend_cnt;
  logic [IDX_W-1:0]   hit_idx;

  iotlb_inval_ctl #(.PEND_W(PEND_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .inv_req(inv_req), .pend_inc(pend_inc),
    .pend_dec(pend_dec), .inv_fire(inv_fire), .busy(busy), .inv_done(inv_done),
    .pend_zero(pend_zero), .pend_cnt(pend_cnt)
  );

  // Walker results are taken only when no flush is active and the walk succeeded.
  assign fill_ok = fill_valid && !fill_fault && !inv_fire && !busy;

  iotlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .hit_vec(fl_vec),
    .alloc(fill_ok), .wr_vec(wr_vec), .evict(evict)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    iotlb_entry #(.DID_W(DID_W)) u_ent (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_vec[g]), .wr_did(fill_did), .wr_gpn(fill_gpn), .wr_hpn(fill_hpn),
      .wr_size(pg_size_e'(fill_size)),
      .inv_fire(inv_fire), .inv_scope(inv_scope_e'(inv_scope)),
      .inv_did(inv_did), .inv_gpn(inv_gpn),
      .lk_did(lk_did), .lk_gpn(lk_gpn),
      .valid(valid_vec[g]), .lk_match(lk_vec[g]), .fl_match(fl_vec[g]),
      .kill(kill_vec[g]), .hpn(e_hpn[g]), .size(e_size[g])
    );
  end

  // Entries being flushed this cycle are already invisible to the lookup.
  assign live_vec = lk_vec & ~kill_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (live_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign lk_hit  = lk_valid && (|live_vec);
  assign lk_hpn  = lk_hit ? join_hpn(e_hpn[hit_idx], e_size[hit_idx], lk_gpn) : '0;
  assign lk_size = lk_hit ? e_size[hit_idx] : 2'd0;
endmodule

// File: rtl/iotlb_scoped_chk.sv
module iotlb_scoped_chk #(
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               inv_done,
  input logic               inv_fire,
  input logic               inv_req,
  input logic [1:0]         inv_scope,
  input logic               busy,
  input logic               pend_zero,
  input logic [ENTRIES-1:0] valid_vec,
  input logic               fill_valid,
  input logic               fill_fault,
  input logic               lk_hit,
  input logic               evict
);
  a_r6_done_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    inv_done |-> $past(pend_zero));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    inv_done |=> !inv_done);

  a_r6_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    inv_fire |=> !inv_done && busy);

  a_r3_fault_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && fill_fault && !inv_req |=> $stable(valid_vec));

  a_r5_busy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(valid_vec));

  a_r7_all_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    inv_fire && inv_scope == 2'd0 |=> valid_vec == '0);

  a_r1_hit_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> |valid_vec);

  a_r4_evict_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    evict |-> &valid_vec);
endmodule

bind iotlb_scoped iotlb_scoped_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .inv_done(inv_done), .inv_fire(inv_fire),
  .inv_req(inv_req), .inv_scope(inv_scope), .busy(busy), .pend_zero(pend_zero),
  .valid_vec(valid_vec), .fill_valid(fill_valid), .fill_fault(fill_fault),
  .lk_hit(lk_hit), .evict(evict)
);

// File: tb/iotlb_scoped_bench.sv
`timescale 1ns/1ps
module iotlb_scoped_bench;
  import iotlb_pkg::*;

  localparam int NE = 4;
  localparam int DW = 8;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic lk_valid = 0, fill_valid = 0, fill_fault = 0, inv_req = 0, pend_inc = 0, pend_dec = 0;
  logic [DW-1:0] lk_did = 0, fill_did = 0, inv_did = 0;
  logic [GPN_W-1:0] lk_gpn = 0, fill_gpn = 0, inv_gpn = 0;
  logic [HPN_W-1:0] fill_hpn = 0;
  logic [1:0] fill_size = 0, inv_scope = 0;
  logic lk_hit, inv_done;
  logic [HPN_W-1:0] lk_hpn;
  logic [1:0] lk_size;

  iotlb_scoped #(.ENTRIES(NE), .DID_W(DW), .PEND_W(PW)) u_iotlb_scoped (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_did(lk_did), .lk_gpn(lk_gpn),
    .lk_hit(lk_hit), .lk_hpn(lk_hpn), .lk_size(lk_size),
    .fill_valid(fill_valid), .fill_fault(fill_fault), .fill_did(fill_did),
    .fill_gpn(fill_gpn), .fill_hpn(fill_hpn), .fill_size(fill_size),
    .inv_req(inv_req), .inv_scope(inv_scope), .inv_did(inv_did), .inv_gpn(inv_gpn),
    .inv_done(inv_done), .pend_inc(pend_inc), .pend_dec(pend_dec)
  );

  // Reference model state
  bit          m_v   [NE];
  int unsigned m_did [NE];
  longint unsigned m_gpn [NE];
  longint unsigned m_hpn [NE];
  int          m_sz  [NE];
  int          m_rr, m_state, m_pend;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R11";
  bit finished = 0;

  function automatic int low_bits(int sz);
    return (sz == 1) ? 9 : (sz == 2) ? 18 : 0;
  endfunction

  function automatic bit covers(int i, longint unsigned g);
    int s;
    s = low_bits(m_sz[i]);
    return (m_gpn[i] >> s) == (g >> s);
  endfunction

  function automatic bit doomed(int i);
    if (!(m_state == 0 && inv_req) || !m_v[i]) return 0;
    case (inv_scope)
      2'd0: return 1;
      2'd1: return m_did[i] == inv_did;
      2'd2: return m_did[i] == inv_did && covers(i, inv_gpn);
      default: return 0;
    endcase
  endfunction

  task automatic check(string what, longint unsigned act, longint unsigned exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int w;
    w = -1;
    if (lk_valid)
      for (int i = NE - 1; i >= 0; i--)
        if (m_v[i] && !doomed(i) && m_did[i] == lk_did && covers(i, lk_gpn)) w = i;
    check("lk_hit", lk_hit, w >= 0);
    if (w >= 0) begin
      longint unsigned s, e;
      s = low_bits(m_sz[w]);
      e = ((m_hpn[w] >> s) << s) | (lk_gpn & ((64'd1 << s) - 1));
      e = e & ((64'd1 << HPN_W) - 1);
      check("lk_hpn", lk_hpn, e);
      check("lk_size", lk_size, m_sz[w]);
    end
    check("inv_done", inv_done, m_state == 2);
  endtask

  task automatic model_edge();
    bit fire;
    int w;
    fire = (m_state == 0) && inv_req;
    if (fire) for (int i = 0; i < NE; i++) if (doomed(i)) m_v[i] = 0;
    if (fill_valid && !fill_fault && !fire && m_state == 0) begin
      w = -1;
      for (int i = NE - 1; i >= 0; i--)
        if (m_v[i] && m_did[i] == fill_did && covers(i, fill_gpn)) w = i;
      if (w < 0) for (int i = NE - 1; i >= 0; i--) if (!m_v[i]) w = i;
      if (w < 0) begin
        w = m_rr;
        m_rr = (m_rr + 1) % NE;
      end
      m_v[w] = 1; m_did[w] = fill_did; m_gpn[w] = fill_gpn;
      m_hpn[w] = fill_hpn; m_sz[w] = fill_size;
    end
    case (m_state)
      0: if (inv_req) m_state = 1;
      1: if (m_pend == 0) m_state = 2;
      default: m_state = 0;
    endcase
    m_pend = m_pend + int'(pend_inc) - int'(pend_dec);
  endtask

  task automatic tick();
    #1;
    compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    fill_valid = 0; fill_fault = 0; inv_req = 0; pend_inc = 0; pend_dec = 0;
  endtask

  task automatic look(int d, longint unsigned g);
    lk_valid = 1; lk_did = DW'(d); lk_gpn = GPN_W'(g);
  endtask

  task automatic fill(int d, longint unsigned g, longint unsigned h, int sz, bit flt);
    fill_valid = 1; fill_fault = flt; fill_did = DW'(d);
    fill_gpn = GPN_W'(g); fill_hpn = HPN_W'(h); fill_size = 2'(sz);
  endtask

  task automatic inval(int sc, int d, longint unsigned g);
    inv_req = 1; inv_scope = 2'(sc); inv_did = DW'(d); inv_gpn = GPN_W'(g);
  endtask

  task automatic run_inval(int sc, int d, longint unsigned g, int ld, longint unsigned lg);
    inval(sc, d, g); look(ld, lg); tick();
    repeat (3) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NE; i++) begin
      m_v[i] = 0; m_did[i] = 0; m_gpn[i] = 0; m_hpn[i] = 0; m_sz[i] = 0;
    end
    m_rr = 0; m_state = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11: nothing cached and no done after reset
    cur_req = "R11"; look(1, 'h100); tick(); tick();

    // R1: basic 4 KB hit, wrong domain misses
    cur_req = "R1"; fill(1, 'h100, 'h5000, 0, 0); look(1, 'h100); tick();
    look(1, 'h100); tick(); look(2, 'h100); tick(); look(1, 'h101); tick();

    // R2: 2 MB and 1 GB entries, offsets taken from lookup
    cur_req = "R2"; fill(1, 'h20005, 'h3_0000_1234, 1, 0); tick();
    look(1, 'h201FF); tick(); look(1, 'h20000); tick(); look(1, 'h20200); tick();
    fill(2, 'h4_0000, 'h2_8000_0000, 2, 0); tick();
    look(2, 'h7_FFFF); tick(); look(2, 'h8_0000); tick();

    // R3: faulting walk is never cached
    cur_req = "R3"; fill(3, 'h999, 'h1, 0, 1); tick(); look(3, 'h999); tick();

    // R4: overwrite on hit, then fill table and evict in rotation
    cur_req = "R4"; fill(1, 'h100, 'h6000, 0, 0); tick(); look(1, 'h100); tick();
    fill(3, 'h10, 'h10, 0, 0); tick();
    for (int k = 0; k < 6; k++) begin
      fill(4, 'h40 + k, 'h100 + k, 0, 0); tick();
      look(4, 'h40 + k); tick(); look(1, 'h100); tick(); look(3, 'h10); tick();
    end

    // R7 + R10: global flush, same-cycle lookup already misses
    cur_req = "R7"; run_inval(0, 0, 0, 4, 'h45); look(4, 'h44); tick();

    // R8: domain flush
    cur_req = "R8"; fill(1, 'h1, 'h11, 0, 0); tick(); fill(2, 'h1, 'h22, 0, 0); tick();
    fill(1, 'h40000, 'h33, 2, 0); tick();
    cur_req = "R10"; run_inval(1, 1, 0, 1, 'h1);
    cur_req = "R8"; look(2, 'h1); tick(); look(1, 'h40001); tick();

    // R9: page flush removes covering large page, scope 3 removes nothing
    cur_req = "R9"; fill(2, 'h40000, 'h44, 2, 0); tick(); fill(2, 'h200, 'h55, 1, 0); tick();
    run_inval(2, 2, 'h5_1234, 2, 'h40000); look(2, 'h201); tick(); look(2, 'h1); tick();
    run_inval(3, 2, 'h200, 2, 'h200); look(2, 'h3FF); tick();

    // R6 + R5 + R12: pending traffic stalls done; fills and requests during flush ignored
    cur_req = "R6"; pend_inc = 1; tick(); pend_inc = 1; tick(); pend_inc = 1; pend_dec = 1; tick();
    cur_req = "R5"; inval(0, 0, 0); fill(5, 'h7, 'h7, 0, 0); tick();
    fill(5, 'h8, 'h8, 0, 0); look(5, 'h7); tick();
    cur_req = "R12"; inval(1, 2, 0); look(2, 'h1); tick(); look(5, 'h8); tick();
    cur_req = "R6"; pend_dec = 1; tick(); tick(); pend_dec = 1; tick();
    repeat (3) tick();
    cur_req = "R5"; look(5, 'h8); tick();

    // Mixed random traffic across all requirements
    cur_req = "R4";
    for (int k = 0; k < 3000; k++) begin
      longint unsigned g;
      g = (longint'($urandom % 3) << 17) | (longint'($urandom % 3) << 8) | ($urandom % 2);
      look(1 + $urandom % 2, g);
      if ($urandom % 3 == 0)
        fill(1 + $urandom % 2, g ^ ($urandom % 2), $urandom, $urandom % 3, ($urandom % 6) == 0);
      if ($urandom % 12 == 0) inval($urandom % 4, 1 + $urandom % 2, g);
      if ($urandom % 5 == 0 && m_pend < 10) pend_inc = 1;
      if ($urandom % 4 == 0 && m_pend > 0) pend_dec = 1;
      tick();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule